// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Multiplexing Transceiver

This block joins one 12-bit port, called A, to a wide side made of two 12-bit halves, called first half and second half. It uses one rising-edge clock. In the A-to-wide direction, each half has its own capture register with its own active-low load enable. Two A words presented on successive clocks can be parked in the two halves. Together the halves then form one 24-bit word. In the wide-to-A direction, a single register takes either half, chosen by a select line, and drives it back onto A.

Every tri-state port is modelled as a data output paired with a drive-enable output. The values that other agents drive onto A and onto each half arrive on separate input buses. The three active-low output enables are captured on the clock, so a port starts or stops driving one edge after its enable changes. When the wide-to-A path reads a half that the block is itself driving, it takes that half's register. Otherwise it takes the externally driven bus.

Top module: `bus_mux_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both half registers and the A register to zero and turns off all three drive enables.
- R2: On a rising edge with `loadFirstN` low, the first-half register takes `aIn`. With `loadFirstN` high it keeps its value.
- R3: On a rising edge with `loadSecondN` low, the second-half register takes `aIn`. With `loadSecondN` high it keeps its value. The two loads are independent and may happen on the same edge.
- R4: Two A words loaded on successive edges, one into each half, appear together as the 24-bit word {`firstOut`, `secondOut`}, with the first half in bits 23:12. Both remain there while the two loads stay high.
- R5: On each rising edge the A register loads the first half when `pickFirst` is 1 and the second half when it is 0. It holds its value between edges.
- R6: For the wide-to-A path, a half whose drive enable is on contributes its own register contents. A half whose drive enable is off contributes its external input bus (`firstIn` or `secondIn`).
- R7: Each drive-enable output equals the inverse of its active-low enable input as sampled on the previous rising edge. A change on the enable input is not visible on the drive enable before that edge.
- R8: A port whose drive enable is off shows zero on its data output. A port whose drive enable is on shows its register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 12 | Value driven onto A by another agent |
| firstIn | input | 12 | Value driven onto the first half by another agent |
| secondIn | input | 12 | Value driven onto the second half by another agent |
| loadFirstN | input | 1 | Active-low load enable of the first-half register |
| loadSecondN | input | 1 | Active-low load enable of the second-half register |
| pickFirst | input | 1 | Wide-to-A select: 1 takes the first half, 0 takes the second half |
| aOeN | input | 1 | Active-low output enable of A |
| firstOeN | input | 1 | Active-low output enable of the first half |
| secondOeN | input | 1 | Active-low output enable of the second half |
| aOut | output | 12 | A register value, zero when not driving |
| aDrive | output | 1 | A is being driven by the block |
| firstOut | output | 12 | First-half register value, zero when not driving |
| firstDrive | output | 1 | First half is being driven by the block |
| secondOut | output | 12 | Second-half register value, zero when not driving |
| secondDrive | output | 1 | Second half is being driven by the block |

## Verification
The assertions assume that every control input is a clean 0 or 1 at each rising edge and that reset lasts at least one edge. After that edge the enables are registered values rather than copies of the reset-cycle inputs. The stimulus changes all inputs only on falling clock edges, holds reset for two edges at the start, and drives every control bit with a defined value in every cycle. This includes the randomised phase, whose values come from a simple arithmetic generator in the bench.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  // Strobes passed from control to datapath, all active high.
  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic pickFirst;
    logic enA;
    logic enFirst;
    logic enSecond;
  } bmx_strobe_t;
endpackage

// File: rtl/bmx_ctrl.sv
module bmx_ctrl
  import bmx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loadFirstN,
  input  logic        loadSecondN,
  input  logic        pickFirst,
  input  logic        aOeN,
  input  logic        firstOeN,
  input  logic        secondOeN,
  output bmx_strobe_t strobe
);
  logic enAQ, enFirstQ, enSecondQ;

  // Output enables take effect one edge after they are sampled.
  always_ff @(posedge clk) begin
    if (rst) begin
      enAQ      <= 1'b0;
      enFirstQ  <= 1'b0;
      enSecondQ <= 1'b0;
    end else begin
      enAQ      <= ~aOeN;
      enFirstQ  <= ~firstOeN;
      enSecondQ <= ~secondOeN;
    end
  end

  always_comb begin
    strobe.loadFirst  = ~loadFirstN;
    strobe.loadSecond = ~loadSecondN;
    strobe.pickFirst  = pickFirst;
    strobe.enA        = enAQ;
    strobe.enFirst    = enFirstQ;
    strobe.enSecond   = enSecondQ;
  end

  // R1
  rst_off_chk: assert property (@(posedge clk)
    rst |=> (!strobe.enA && !strobe.enFirst && !strobe.enSecond));

  // R7
  oe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (strobe.enFirst == !$past(firstOeN)) && (strobe.enA == !$past(aOeN)));
endmodule

// File: rtl/bmx_datapath.sv
module bmx_datapath
  import bmx_pkg::*;
#(
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  bmx_strobe_t       strobe,
  input  logic [HALF_W-1:0] aIn,
  input  logic [HALF_W-1:0] firstIn,
  input  logic [HALF_W-1:0] secondIn,
  output logic [HALF_W-1:0] aOut,
  output logic [HALF_W-1:0] firstOut,
  output logic [HALF_W-1:0] secondOut
);
  localparam int HALVES = 2;

  logic [HALF_W-1:0] halfReg [HALVES];
  logic [HALF_W-1:0] halfExt [HALVES];
  logic [HALF_W-1:0] halfSrc [HALVES];
  logic [HALVES-1:0] loadVec;
  logic [HALVES-1:0] enVec;
  logic [HALF_W-1:0] aReg;

  assign loadVec    = {strobe.loadSecond, strobe.loadFirst};
  assign enVec      = {strobe.enSecond, strobe.enFirst};
  assign halfExt[0] = firstIn;
  assign halfExt[1] = secondIn;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)             halfReg[h] <= '0;
      else if (loadVec[h]) halfReg[h] <= aIn;
    end
    // A half that the block drives is read back from its own register.
    assign halfSrc[h] = enVec[h] ? halfReg[h] : halfExt[h];
  end

  always_ff @(posedge clk) begin
    if (rst) aReg <= '0;
    else     aReg <= strobe.pickFirst ? halfSrc[0] : halfSrc[1];
  end

  assign aOut      = strobe.enA      ? aReg       : '0;
  assign firstOut  = strobe.enFirst  ? halfReg[0] : '0;
  assign secondOut = strobe.enSecond ? halfReg[1] : '0;

  // R2
  first_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.loadFirst |=> halfReg[0] == $past(aIn));
  // R2
  first_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadFirst |=> $stable(halfReg[0]));
  // R3
  second_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.loadSecond |=> halfReg[1] == $past(aIn));
  // R3
  second_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadSecond |=> $stable(halfReg[1]));
  // R5
  pick_first_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.pickFirst && strobe.enFirst) |=> aReg == $past(halfReg[0]));
  // R6
  pick_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.pickFirst && !strobe.enSecond) |=> aReg == $past(secondIn));
endmodule

// File: rtl/bus_mux_xcvr.sv
module bus_mux_xcvr
  import bmx_pkg::*;
#(
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] aIn,
  input  logic [HALF_W-1:0] firstIn,
  input  logic [HALF_W-1:0] secondIn,
  input  logic              loadFirstN,
  input  logic              loadSecondN,
  input  logic              pickFirst,
  input  logic              aOeN,
  input  logic              firstOeN,
  input  logic              secondOeN,
  output logic [HALF_W-1:0] aOut,
  output logic              aDrive,
  output logic [HALF_W-1:0] firstOut,
  output logic              firstDrive,
  output logic [HALF_W-1:0] secondOut,
  output logic              secondDrive
);
  bmx_strobe_t strobe;

  bmx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .loadFirstN(loadFirstN), .loadSecondN(loadSecondN),
    .pickFirst(pickFirst),
    .aOeN(aOeN), .firstOeN(firstOeN), .secondOeN(secondOeN),
    .strobe(strobe)
  );

  bmx_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .aIn(aIn), .firstIn(firstIn), .secondIn(secondIn),
    .aOut(aOut), .firstOut(firstOut), .secondOut(secondOut)
  );

  assign aDrive      = strobe.enA;
  assign firstDrive  = strobe.enFirst;
  assign secondDrive = strobe.enSecond;

  // R8
  quiet_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(firstDrive) |-> firstOut == '0);
endmodule

// File: tb/bus_mux_xcvr_bench.sv
module bus_mux_xcvr_bench;
  localparam int W = 12;

  typedef struct packed {
    logic [W-1:0] a, f, s;
    logic ea, ef, es;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, firstIn = '0, secondIn = '0;
  logic loadFirstN = 1'b1, loadSecondN = 1'b1, pickFirst = 1'b0;
  logic aOeN = 1'b1, firstOeN = 1'b1, secondOeN = 1'b1;
  logic [W-1:0] aOut, firstOut, secondOut;
  logic aDrive, firstDrive, secondDrive;

  int compared = 0;
  int mismatched = 0;
  exp_t  expQ[$];
  string tagQ[$];

  // Reference state, from the requirements
  logic [W-1:0] mA = '0, mF = '0, mS = '0;
  logic mEa = 1'b0, mEf = 1'b0, mEs = 1'b0;

  always #2 clk = ~clk;

  bus_mux_xcvr u_bus_mux_xcvr (
    .clk(clk), .rst(rst), .aIn(aIn), .firstIn(firstIn), .secondIn(secondIn),
    .loadFirstN(loadFirstN), .loadSecondN(loadSecondN), .pickFirst(pickFirst),
    .aOeN(aOeN), .firstOeN(firstOeN), .secondOeN(secondOeN),
    .aOut(aOut), .aDrive(aDrive), .firstOut(firstOut), .firstDrive(firstDrive),
    .secondOut(secondOut), .secondDrive(secondDrive)
  );

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the expected outputs after the next edge.
  task automatic cyc(input logic r, input logic l1N, input logic l2N, input logic sel,
                     input logic oaN, input logic ofN, input logic osN,
                     input logic [W-1:0] a, input logic [W-1:0] fx, input logic [W-1:0] sx,
                     input string tag);
    exp_t e;
    logic [W-1:0] srcF, srcS;
    @(negedge clk);
    rst = r; loadFirstN = l1N; loadSecondN = l2N; pickFirst = sel;
    aOeN = oaN; firstOeN = ofN; secondOeN = osN;
    aIn = a; firstIn = fx; secondIn = sx;
    if (r) begin
      mA = '0; mF = '0; mS = '0; mEa = 0; mEf = 0; mEs = 0;
    end else begin
      srcF = mEf ? mF : fx;
      srcS = mEs ? mS : sx;
      mA = sel ? srcF : srcS;
      if (!l1N) mF = a;
      if (!l2N) mS = a;
      mEa = !oaN; mEf = !ofN; mEs = !osN;
    end
    e.a = mEa ? mA : '0; e.f = mEf ? mF : '0; e.s = mEs ? mS : '0;
    e.ea = mEa; e.ef = mEf; e.es = mEs;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, "aOut", aOut, e.a);
        check(t, "firstOut", firstOut, e.f);
        check(t, "secondOut", secondOut, e.s);
        check(t, "drives", {9'd0, aDrive, firstDrive, secondDrive}, {9'd0, e.ea, e.ef, e.es});
      end
    end
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] rnd;
    rnd = 12'h5A3;
    // R1 reset state
    cyc(1, 1,1,0, 0,0,0, 12'hFFF, 12'hFFF, 12'hFFF, "R1");
    cyc(1, 0,0,1, 0,0,0, 12'hEEE, 12'hDDD, 12'hCCC, "R1");
    // R7: enable all outputs; the drive must stay off until the edge
    cyc(0, 1,1,0, 0,0,0, 12'h000, 12'h000, 12'h000, "R7");
    #1 check("R7", "firstDrive before edge", {11'd0, firstDrive}, 12'd0);
    // R4: two successive words assembled
    cyc(0, 0,1,0, 0,0,0, 12'hABC, 12'h000, 12'h000, "R2");
    cyc(0, 1,0,0, 0,0,0, 12'h123, 12'h000, 12'h000, "R3");
    cyc(0, 1,1,0, 0,0,0, 12'hFFF, 12'h000, 12'h000, "R4");
    #1 check("R4", "combined hi", firstOut, 12'hABC);
    check("R4", "combined lo", secondOut, 12'h123);
    // R2 / R3 hold while loads are high
    cyc(0, 1,1,1, 0,0,0, 12'h777, 12'h000, 12'h000, "R2");
    cyc(0, 1,1,0, 0,0,0, 12'h888, 12'h000, 12'h000, "R3");
    // R3 both halves on the same edge
    cyc(0, 0,0,0, 0,0,0, 12'h5A5, 12'h000, 12'h000, "R3");
    cyc(0, 0,1,0, 0,0,0, 12'h111, 12'h000, 12'h000, "R2");
    cyc(0, 1,0,0, 0,0,0, 12'h222, 12'h000, 12'h000, "R3");
    // R5 select alternating, own registers
    cyc(0, 1,1,1, 0,0,0, 12'h000, 12'h3C3, 12'h4D4, "R5");
    cyc(0, 1,1,0, 0,0,0, 12'h000, 12'h3C3, 12'h4D4, "R5");
    cyc(0, 1,1,1, 0,0,0, 12'h000, 12'h3C3, 12'h4D4, "R5");
    cyc(0, 1,1,0, 0,0,0, 12'h000, 12'h3C3, 12'h4D4, "R5");
    // R6 / R8: halves released, external buses read back
    cyc(0, 1,1,1, 0,1,1, 12'h000, 12'h3C3, 12'h4D4, "R8");
    cyc(0, 1,1,1, 0,1,1, 12'h000, 12'h3C3, 12'h4D4, "R6");
    cyc(0, 1,1,0, 0,1,1, 12'h000, 12'h3C3, 12'h4D4, "R6");
    cyc(0, 1,1,1, 0,1,1, 12'h000, 12'h6E6, 12'h7F7, "R6");
    // R8: A released, then R7 re-enable
    cyc(0, 1,1,0, 1,0,1, 12'h000, 12'h6E6, 12'h7F7, "R8");
    cyc(0, 1,1,0, 1,0,1, 12'h000, 12'h6E6, 12'h7F7, "R8");
    cyc(0, 1,1,1, 0,0,1, 12'h000, 12'h6E6, 12'h7F7, "R7");
    #1 check("R7", "aDrive before edge", {11'd0, aDrive}, 12'd0);
    cyc(0, 1,1,1, 0,0,0, 12'h000, 12'h6E6, 12'h7F7, "R5");
    // Mixed traffic, R6
    for (int i = 0; i < 40; i++) begin
      rnd = rnd * 12'd13 + 12'd7;
      cyc(0, rnd[0], rnd[1], rnd[2], rnd[3], rnd[4], rnd[5],
          rnd, ~rnd, {rnd[5:0], rnd[11:6]}, "R6");
    end
    cyc(0, 1,1,0, 0,0,0, 12'h000, 12'h000, 12'h000, "R2");
    repeat (3) @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule